// File: doc/BRIEF.md
# Debug Port Control and Status Register with Power Handshake

This block holds the control/status word of a debug port. The word carries the power-up requests for the debug domain and the system domain, and the acknowledge that comes back from the power controller for each. It also carries an overrun-detect enable and two sticky error flags. One flag records an access-port transaction that ended in a fault. The other records a transaction attempted while an earlier one was still pending. The register access logic writes the word through a one-cycle write strobe and reads it through a read-data bus that always shows the current value.

The expected bring-up order has three steps. First request both domains. Then poll the word until both acknowledges read high. Only then turn on overrun detection. The acknowledges arrive from another clock domain, so they pass through a synchroniser before they appear in the word. The overrun enable can only be changed while both synchronised acknowledges are high.

Both sticky flags are cleared by writing ones to their positions. While either flag is set, the block raises a refuse output. The transaction logic uses it to answer further access-port transactions with a fault.

Top module: `dbg_ctrl_stat`

## Requirements
- R1: A synchronous reset makes `reg_rdata` read 0, drives both request outputs low and drives `txn_block` low.
- R2: A write sets `pwr_dbg_req` from `reg_wdata[28]` and `pwr_sys_req` from `reg_wdata[30]` on the next cycle. The same values read back at bits 28 and 30.
- R3: The debug acknowledge reads at bit 29 and the system acknowledge at bit 31. Each is delayed by SYNC_STAGES clock edges (default 2). With both domains requested and acknowledged, `reg_rdata[31:28]` reads 4'hF.
- R4: Bit 0 is the overrun-detect enable. A write loads it from `reg_wdata[0]` only while bits 29 and 31 both read 1. Otherwise it keeps its value.
- R5: A cycle with `evt_fault` high sets the error flag at bit 4 from the next cycle.
- R6: A cycle with the enable set, `evt_attempt` high and `txn_pending` high sets the overrun flag at bit 1 from the next cycle. With the enable at 0, no attempt sets it.
- R7: Writing 1 to bit 1 or bit 4 clears that flag, and writing 0 leaves it unchanged. A set event in the same cycle as the clearing write wins, and the flag stays set.
- R8: `txn_block` is high in exactly the cycles in which bit 1 or bit 4 reads 1.
- R9: All bits other than 0, 1, 4 and 28 to 31 read 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the word, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current value of the word |
| pwr_dbg_req | output | 1 | Debug-domain power-up request |
| pwr_sys_req | output | 1 | System-domain power-up request |
| pwr_dbg_ack | input | 1 | Debug-domain power-up acknowledge, asynchronous |
| pwr_sys_ack | input | 1 | System-domain power-up acknowledge, asynchronous |
| evt_fault | input | 1 | Pulse: an access-port transaction ended with a fault |
| evt_attempt | input | 1 | Pulse: a new access-port transaction is attempted |
| txn_pending | input | 1 | Level: an earlier transaction has not completed |
| txn_block | output | 1 | Refuse further transactions while a sticky flag is set |

## Verification
Writes, fault pulses and overrun attempts all act one clock edge after they are sampled. An acknowledge change appears SYNC_STAGES edges later. `txn_block` follows the flags in the same cycle. The reference model in the bench updates on the same rising edge as the design and delays the acknowledges through a queue of SYNC_STAGES entries. Each output is compared with the model at the falling edge. The directed checks also sample at a falling edge, after exactly the number of edges stated above.

// File: rtl/dpcs_pkg.sv
package dpcs_pkg;

    localparam int CSR_W     = 32;
    localparam int B_SYS_ACK = 31;
    localparam int B_SYS_REQ = 30;
    localparam int B_DBG_ACK = 29;
    localparam int B_DBG_REQ = 28;
    localparam int B_ERR     = 4;
    localparam int B_ORUN    = 1;
    localparam int B_ORUN_EN = 0;

    // index of each power domain inside the paired vectors
    typedef enum int {DOM_DBG = 0, DOM_SYS = 1} dom_e;
    localparam int N_DOM = 2;

    typedef struct packed {
        logic sys;
        logic dbg;
    } dom_pair_t;

    typedef struct packed {
        dom_pair_t req;
        dom_pair_t ack;
        logic      orun_en;
        logic      orun;
        logic      err;
    } csr_t;

    function automatic logic [CSR_W-1:0] csr_pack(csr_t c);
        logic [CSR_W-1:0] w;
        w            = '0;
        w[B_SYS_ACK] = c.ack.sys;
        w[B_SYS_REQ] = c.req.sys;
        w[B_DBG_ACK] = c.ack.dbg;
        w[B_DBG_REQ] = c.req.dbg;
        w[B_ERR]     = c.err;
        w[B_ORUN]    = c.orun;
        w[B_ORUN_EN] = c.orun_en;
        return w;
    endfunction

    function automatic logic w1c_hit(logic wr, logic [CSR_W-1:0] wd, int pos);
        return wr & wd[pos];
    endfunction

endpackage

// File: rtl/dpcs_ack_sync.sv
module dpcs_ack_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else if (STAGES == 1) chain <= async_i[b];
            else chain <= {chain[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain[LAST];
    end
endmodule

// File: rtl/dpcs_sticky.sv
module dpcs_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;   // a new event outranks a clear
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/dpcs_ctrl.sv
module dpcs_ctrl
    import dpcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CSR_W-1:0] wdata_i,
    input  dom_pair_t        ack_sync_i,
    output dom_pair_t        req_o,
    output logic             orun_en_o
);
    logic pwr_ok;
    assign pwr_ok = ack_sync_i.dbg & ack_sync_i.sys;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o     <= '0;
            orun_en_o <= 1'b0;
        end else if (wr_i) begin
            req_o.dbg <= wdata_i[B_DBG_REQ];
            req_o.sys <= wdata_i[B_SYS_REQ];
            if (pwr_ok) orun_en_o <= wdata_i[B_ORUN_EN];
        end
    end
endmodule

// File: rtl/dbg_ctrl_stat.sv
module dbg_ctrl_stat
    import dpcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [CSR_W-1:0] reg_wdata,
    output logic [CSR_W-1:0] reg_rdata,
    output logic             pwr_dbg_req,
    output logic             pwr_sys_req,
    input  logic             pwr_dbg_ack,
    input  logic             pwr_sys_ack,
    input  logic             evt_fault,
    input  logic             evt_attempt,
    input  logic             txn_pending,
    output logic             txn_block
);
    dom_pair_t ack_raw, ack_s, req;
    logic      orun_en, orun_evt, err_f, orun_f;
    csr_t      csr;

    assign ack_raw.dbg = pwr_dbg_ack;
    assign ack_raw.sys = pwr_sys_ack;

    dpcs_ack_sync #(.WIDTH(N_DOM), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(ack_raw), .sync_o(ack_s)
    );

    dpcs_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_i(reg_wr), .wdata_i(reg_wdata),
        .ack_sync_i(ack_s), .req_o(req), .orun_en_o(orun_en)
    );

    assign orun_evt = orun_en & evt_attempt & txn_pending;

    dpcs_sticky u_err (
        .clk(clk), .rst(rst), .set_i(evt_fault),
        .clr_i(w1c_hit(reg_wr, reg_wdata, B_ERR)), .flag_o(err_f)
    );

    dpcs_sticky u_orun (
        .clk(clk), .rst(rst), .set_i(orun_evt),
        .clr_i(w1c_hit(reg_wr, reg_wdata, B_ORUN)), .flag_o(orun_f)
    );

    always_comb begin
        csr.req     = req;
        csr.ack     = ack_s;
        csr.orun_en = orun_en;
        csr.orun    = orun_f;
        csr.err     = err_f;
    end

    assign reg_rdata   = csr_pack(csr);
    assign pwr_dbg_req = req.dbg;
    assign pwr_sys_req = req.sys;
    assign txn_block   = err_f | orun_f;
endmodule

// File: rtl/dbg_ctrl_stat_chk.sv
module dbg_ctrl_stat_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        pwr_dbg_req,
    input logic        pwr_sys_req,
    input logic        evt_fault,
    input logic        evt_attempt,
    input logic        txn_pending,
    input logic        txn_block
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (reg_rdata == 32'h0 && !pwr_dbg_req && !pwr_sys_req && !txn_block));

    a_r2_req_follows_write: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (pwr_dbg_req == $past(reg_wdata[28]) && pwr_sys_req == $past(reg_wdata[30])));

    a_r4_enable_gated: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !(reg_rdata[29] && reg_rdata[31])) |=> $stable(reg_rdata[0]));

    a_r5_fault_sets_err: assert property (@(posedge clk) disable iff (rst)
        evt_fault |=> reg_rdata[4]);

    a_r6_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[0] && evt_attempt && txn_pending) |=> reg_rdata[1]);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[4] && !(reg_wr && reg_wdata[4])) |=> reg_rdata[4]);

    a_r8_block_on_fault: assert property (@(posedge clk) disable iff (rst)
        evt_fault |=> txn_block);

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata[27:5] == 23'h0 && reg_rdata[3:2] == 2'b00));
endmodule

bind dbg_ctrl_stat dbg_ctrl_stat_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwr_dbg_req(pwr_dbg_req), .pwr_sys_req(pwr_sys_req),
    .evt_fault(evt_fault), .evt_attempt(evt_attempt), .txn_pending(txn_pending),
    .txn_block(txn_block)
);

// File: tb/sim_dbg_ctrl_stat.sv
module sim_dbg_ctrl_stat;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwr_dbg_req, pwr_sys_req, txn_block;
    logic        pwr_dbg_ack = 1'b0, pwr_sys_ack = 1'b0;
    logic        evt_fault = 1'b0, evt_attempt = 1'b0, txn_pending = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_ctrl_stat #(.SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pwr_dbg_req(pwr_dbg_req), .pwr_sys_req(pwr_sys_req),
        .pwr_dbg_ack(pwr_dbg_ack), .pwr_sys_ack(pwr_sys_ack), .evt_fault(evt_fault),
        .evt_attempt(evt_attempt), .txn_pending(txn_pending), .txn_block(txn_block)
    );

    // behavioural reference model
    bit m_dreq, m_sreq, m_en, m_err, m_orun;
    bit q_d[$];
    bit q_s[$];

    function automatic bit m_dack(); return q_d[0]; endfunction
    function automatic bit m_sack(); return q_s[0]; endfunction

    function automatic logic [31:0] m_word();
        logic [31:0] w = '0;
        w[31] = m_sack(); w[30] = m_sreq; w[29] = m_dack(); w[28] = m_dreq;
        w[4] = m_err; w[1] = m_orun; w[0] = m_en;
        return w;
    endfunction

    initial begin
        for (int i = 0; i < SYNC; i++) begin q_d.push_back(1'b0); q_s.push_back(1'b0); end
    end

    always @(posedge clk) begin
        bit pok;
        pok = m_dack() && m_sack();
        if (rst) begin
            m_dreq = 0; m_sreq = 0; m_en = 0; m_err = 0; m_orun = 0;
            q_d.delete(); q_s.delete();
            for (int i = 0; i < SYNC; i++) begin q_d.push_back(1'b0); q_s.push_back(1'b0); end
        end else begin
            m_err  = (m_err  && !(reg_wr && reg_wdata[4])) || evt_fault;
            m_orun = (m_orun && !(reg_wr && reg_wdata[1])) || (m_en && evt_attempt && txn_pending);
            if (reg_wr) begin
                m_dreq = reg_wdata[28];
                m_sreq = reg_wdata[30];
                if (pok) m_en = reg_wdata[0];
            end
            q_d.push_back(pwr_dbg_ack); void'(q_d.pop_front());
            q_s.push_back(pwr_sys_ack); void'(q_s.pop_front());
        end
        live = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // compare against the model on every clock, away from the rising edge
    always @(negedge clk) begin
        logic [31:0] e;
        if (live && !done) begin
            e = m_word();
            chk(reg_rdata[31] == e[31] && reg_rdata[29] == e[29], "R3 ack bits", reg_rdata, e);
            chk(reg_rdata[30] == e[30] && reg_rdata[28] == e[28] &&
                pwr_dbg_req == m_dreq && pwr_sys_req == m_sreq, "R2 request bits", reg_rdata, e);
            chk(reg_rdata[0] == e[0], "R4 overrun enable", reg_rdata, e);
            chk(reg_rdata[1] == e[1], "R6 overrun flag", reg_rdata, e);
            chk(reg_rdata[4] == e[4], "R5 error flag", reg_rdata, e);
            chk({reg_rdata[27:5], reg_rdata[3:2]} == '0, "R9 reserved bits", reg_rdata, e);
            chk(txn_block == (m_err || m_orun), "R8 refuse output", {31'h0, txn_block},
                {31'h0, m_err || m_orun});
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1'b1; reg_wdata = d; step(1); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        // R1: reset state
        chk(reg_rdata == 32'h0 && !pwr_dbg_req && !pwr_sys_req && !txn_block,
            "R1 reset state", reg_rdata, 32'h0);

        // R2, R4: request both domains, enable write ignored without power
        wr(32'h5000_0001);
        chk(pwr_dbg_req && pwr_sys_req, "R2 requests driven", reg_rdata, 32'h5000_0000);
        chk(reg_rdata == 32'h5000_0000, "R4 enable ignored while unpowered", reg_rdata, 32'h5000_0000);

        // R3: acknowledges appear after SYNC edges
        pwr_dbg_ack = 1'b1; pwr_sys_ack = 1'b1;
        step(SYNC - 1);
        chk(reg_rdata[31:28] == 4'h5, "R3 ack not yet visible", {28'h0, reg_rdata[31:28]}, 32'h5);
        step(1);
        chk(reg_rdata[31:28] == 4'hF, "R3 fully powered", {28'h0, reg_rdata[31:28]}, 32'hF);

        // R4: enable accepted with power
        wr(32'h5000_0001);
        chk(reg_rdata[0], "R4 enable set", reg_rdata, 32'hF000_0001);

        // R6: attempt without pending does nothing, with pending sets overrun
        evt_attempt = 1'b1; step(1); evt_attempt = 1'b0;
        chk(!reg_rdata[1], "R6 no overrun without pending", reg_rdata, 32'hF000_0001);
        evt_attempt = 1'b1; txn_pending = 1'b1; step(1); evt_attempt = 1'b0; txn_pending = 1'b0;
        chk(reg_rdata[1] && txn_block, "R6 overrun flagged, R8 block", reg_rdata, 32'hF000_0003);

        // R5: fault sets error
        evt_fault = 1'b1; step(1); evt_fault = 1'b0;
        chk(reg_rdata[4], "R5 error set", reg_rdata, 32'hF000_0013);

        // R7: write 0 keeps, set-with-clear keeps, write 1 clears
        wr(32'h5000_0001);
        chk(reg_rdata[4] && reg_rdata[1], "R7 zero write keeps flags", reg_rdata, 32'hF000_0013);
        evt_fault = 1'b1; wr(32'h5000_0013); evt_fault = 1'b0;
        chk(reg_rdata[4] && !reg_rdata[1], "R7 set wins, overrun cleared", reg_rdata, 32'hF000_0011);
        chk(txn_block, "R8 block while error", {31'h0, txn_block}, 32'h1);
        wr(32'h5000_0011);
        chk(!reg_rdata[4] && !txn_block, "R7 error cleared, R8 released", reg_rdata, 32'hF000_0001);

        // R9: all-ones write
        wr(32'hFFFF_FFFF);
        chk(reg_rdata == 32'hF000_0001, "R9 reserved read zero", reg_rdata, 32'hF000_0001);

        // R6: enable off, no overrun
        wr(32'h5000_0000);
        evt_attempt = 1'b1; txn_pending = 1'b1; step(1); evt_attempt = 1'b0; txn_pending = 1'b0;
        chk(!reg_rdata[1], "R6 disabled no overrun", reg_rdata, 32'hF000_0000);

        // R3: system ack drops
        pwr_sys_ack = 1'b0; step(SYNC);
        chk(reg_rdata[31:28] == 4'h7, "R3 system ack dropped", {28'h0, reg_rdata[31:28]}, 32'h7);
        // R4: enable write refused again
        wr(32'h5000_0001);
        chk(!reg_rdata[0], "R4 enable refused after power loss", reg_rdata, 32'h7000_0000);

        // mixed stimulus, compared by the per-cycle model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            reg_wr      = r[0] & r[1];
            reg_wdata   = {$urandom} | 32'h0;
            evt_fault   = r[2] & r[3] & r[4];
            evt_attempt = r[5];
            txn_pending = r[6];
            if (r[7] & r[8] & r[9]) pwr_dbg_ack = ~pwr_dbg_ack;
            if (r[10] & r[11] & r[12]) pwr_sys_ack = ~pwr_sys_ack;
            step(1);
        end
        reg_wr = 1'b0; evt_fault = 1'b0; evt_attempt = 1'b0; txn_pending = 1'b0;

        // R1: reset mid-run
        rst = 1'b1; step(1); rst = 1'b0;
        chk(reg_rdata[28] == 1'b0 && reg_rdata[4:0] == 5'h0 && !txn_block,
            "R1 reset mid-run", reg_rdata, 32'h0);
        step(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule